// File: doc/BRIEF.md
# Probe-Driven Bit Permutation Learner

This block recovers the hidden permutation between the logical positions of a 16-entry truth table and the physical cells that hold it. A probe generator outside the block feeds it one pair per probe: a logical vector with one set bit, and the physical vector observed for that setting. The block finds the single odd bit in the physical response, then stores which physical position belongs to that logical position. The first well-formed response also tells the block whether the device stores cells complemented. In that case every response is a single-zero vector rather than a single-one vector.

Once all sixteen logical positions hold distinct physical positions, the table is complete. A separate conversion port then takes any physical vector and returns the logical truth table it encodes. The port applies the learned permutation and, where needed, the complement. The result appears one clock later. Malformed responses and two logical positions that claim the same physical cell raise sticky error flags, and neither writes the table.

Top module: `perm_learner`

## Requirements
- R1: After rst_ni low or a cycle with clear_i high, no table entry is valid, polarity is undetermined (pol_known_o=0, pol_inv_o=0), both error flags are 0, done_o=0 and probe_ready_o=1.
- R2: With polarity undetermined, the first accepted probe whose physical vector has exactly one 1 fixes polarity as plain (pol_inv_o=0). One with exactly fifteen 1s fixes it as complemented (pol_inv_o=1). Polarity then holds until clear. A response that does not fit the fixed polarity sets err_shape_o.
- R3: An accepted well-formed probe with logical bit L set maps logical index L to physical index P. P is the position of the single 1 (plain) or the single 0 (complemented). For example, logical 16'h0080 with plain response 16'h2000 records 7 to 13.
- R4: A probe whose logical vector is not one-hot, or whose corrected physical vector is not one-hot, sets err_shape_o (sticky). It writes no entry and fixes no polarity.
- R5: A well-formed probe whose physical index already belongs to a different logical index sets err_collide_o (sticky) and writes nothing. Repeating an identical pair is not a collision.
- R6: done_o is 1 exactly when all 16 entries are valid. probe_ready_o is the inverse of done_o. Probes offered while done_o=1 change nothing.
- R7: A conversion request accepted while done_o=1 gives conv_valid_o=1 on the next cycle, with conv_log_o[L] = conv_phy_i[map(L)] XOR pol_inv_o for every L.
- R8: A conversion request made while done_o=0 produces no conv_valid_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of table, polarity and errors |
| probe_valid_i | input | 1 | Probe pair offered |
| probe_ready_o | output | 1 | Probe accepted this cycle when valid |
| probe_log_i | input | 16 | Logical vector of the probe (one-hot) |
| probe_phy_i | input | 16 | Physical response to the probe |
| conv_req_i | input | 1 | Conversion request |
| conv_phy_i | input | 16 | Physical vector to convert |
| conv_valid_o | output | 1 | Conversion result valid |
| conv_log_o | output | 16 | Converted logical truth table |
| done_o | output | 1 | Table complete |
| pol_known_o | output | 1 | Polarity determined |
| pol_inv_o | output | 1 | Device stores cells complemented |
| err_shape_o | output | 1 | Malformed probe seen |
| err_collide_o | output | 1 | Physical index collision seen |

## Verification
The assertions check on every cycle that polarity stays fixed once known and that a malformed probe leaves the valid set unchanged. They also check that a complete table stays complete, that the number of claimed physical cells always equals the number of valid entries, and that a conversion result only follows a request made while done. Only the bench's scenarios can show that the recovered permutation is the right one and that conversion of arbitrary vectors matches it under both polarities. The same holds for recovery after a rejected probe and for filling the table after a collision.

// File: rtl/perm_pkg.sv
package perm_pkg;
  typedef enum logic [1:0] {
    POL_UNK  = 2'd0,
    POL_NORM = 2'd1,
    POL_INV  = 2'd2
  } pol_e;
endpackage

// File: rtl/perm_onehot_loc.sv
module perm_onehot_loc #(
  parameter int N = 16,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] idx_o,
  output logic [W:0]   cnt_o,
  output logic         single_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    cnt_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec_i[k]) idx_o = W'(k);
      cnt_o = cnt_o + (W + 1)'(vec_i[k]);
    end
  end

  assign single_o = (cnt_o == (W + 1)'(1));

  always_comb begin
    if (single_o) AST_LOC_HIT: assert (vec_i[idx_o]); // R3
  end
endmodule

// File: rtl/perm_map_table.sv
module perm_map_table #(
  parameter int N = 16,
  parameter int W = $clog2(N)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           wr_i,
  input  logic [W-1:0]   log_idx_i,
  input  logic [W-1:0]   phy_idx_i,
  output logic           collide_o,
  output logic [N-1:0]   valid_o,
  output logic [N*W-1:0] map_o
);
  logic [W-1:0] map_q [N];
  logic [N-1:0] valid_q;
  logic [N-1:0] used;
  logic         same_pair;
  logic         wr_ok;

  always_comb begin
    used = '0;
    for (int l = 0; l < N; l++) begin
      if (valid_q[l]) used[map_q[l]] = 1'b1;
    end
  end

  assign same_pair = valid_q[log_idx_i] && (map_q[log_idx_i] == phy_idx_i);
  assign collide_o = used[phy_idx_i] && !same_pair;
  assign wr_ok     = wr_i && !collide_o;

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        map_q[g]   <= '0;
      end else if (clear_i) begin
        valid_q[g] <= 1'b0;
      end else if (wr_ok && (log_idx_i == W'(g))) begin
        valid_q[g] <= 1'b1;
        map_q[g]   <= phy_idx_i;
      end
    end
    assign map_o[g*W +: W] = map_q[g];
  end

  assign valid_o = valid_q;

  AST_PHYS_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(used) == $countones(valid_q)); // R5
endmodule

// File: rtl/perm_apply.sv
module perm_apply #(
  parameter int N = 16,
  parameter int W = $clog2(N)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           req_i,
  input  logic           en_i,
  input  logic           inv_i,
  input  logic [N-1:0]   phy_i,
  input  logic [N*W-1:0] map_i,
  output logic           valid_o,
  output logic [N-1:0]   log_o
);
  logic [N-1:0] log_d;
  logic         take;

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign log_d[g] = phy_i[map_i[g*W +: W]] ^ inv_i;
  end

  assign take = req_i && en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      log_o   <= '0;
    end else if (clear_i) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= take;
      if (take) log_o <= log_d;
    end
  end

  AST_CONV_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(req_i && en_i && !clear_i)); // R8
endmodule

// File: rtl/perm_learner.sv
module perm_learner #(
  parameter int N = 16,
  localparam int W = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         probe_valid_i,
  output logic         probe_ready_o,
  input  logic [N-1:0] probe_log_i,
  input  logic [N-1:0] probe_phy_i,
  input  logic         conv_req_i,
  input  logic [N-1:0] conv_phy_i,
  output logic         conv_valid_o,
  output logic [N-1:0] conv_log_o,
  output logic         done_o,
  output logic         pol_known_o,
  output logic         pol_inv_o,
  output logic         err_shape_o,
  output logic         err_collide_o
);
  import perm_pkg::*;

  pol_e           pol_q;
  logic           err_shape_q, err_col_q;
  logic           fire, inv_eff, shape_ok, collide;
  logic [N-1:0]   phy_corr;
  logic [W-1:0]   raw_idx, phy_idx, log_idx;
  logic [W:0]     raw_cnt, phy_cnt, log_cnt;
  logic           raw_one, phy_one, log_one;
  logic [N-1:0]   valid;
  logic [N*W-1:0] map;

  assign done_o        = &valid;
  assign probe_ready_o = !done_o;
  assign fire          = probe_valid_i && probe_ready_o;

  perm_onehot_loc #(.N(N), .W(W)) u_raw (
    .vec_i(probe_phy_i), .idx_o(raw_idx), .cnt_o(raw_cnt), .single_o(raw_one)
  );

  // undetermined polarity: a fifteen-ones response selects complement
  assign inv_eff  = (pol_q == POL_INV) ||
                    ((pol_q == POL_UNK) && (raw_cnt == (W + 1)'(N - 1)));
  assign phy_corr = probe_phy_i ^ {N{inv_eff}};

  perm_onehot_loc #(.N(N), .W(W)) u_phy (
    .vec_i(phy_corr), .idx_o(phy_idx), .cnt_o(phy_cnt), .single_o(phy_one)
  );

  perm_onehot_loc #(.N(N), .W(W)) u_log (
    .vec_i(probe_log_i), .idx_o(log_idx), .cnt_o(log_cnt), .single_o(log_one)
  );

  assign shape_ok = phy_one && log_one;

  perm_map_table #(.N(N), .W(W)) u_tbl (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i),
    .wr_i(fire && shape_ok), .log_idx_i(log_idx), .phy_idx_i(phy_idx),
    .collide_o(collide), .valid_o(valid), .map_o(map)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q       <= POL_UNK;
      err_shape_q <= 1'b0;
      err_col_q   <= 1'b0;
    end else if (clear_i) begin
      pol_q       <= POL_UNK;
      err_shape_q <= 1'b0;
      err_col_q   <= 1'b0;
    end else if (fire) begin
      if (!shape_ok) err_shape_q <= 1'b1;
      else if (collide) err_col_q <= 1'b1;
      if (shape_ok && !collide && (pol_q == POL_UNK))
        pol_q <= inv_eff ? POL_INV : POL_NORM;
    end
  end

  assign pol_known_o   = (pol_q != POL_UNK);
  assign pol_inv_o     = (pol_q == POL_INV);
  assign err_shape_o   = err_shape_q;
  assign err_collide_o = err_col_q;

  perm_apply #(.N(N), .W(W)) u_apply (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i),
    .req_i(conv_req_i), .en_i(done_o), .inv_i(pol_inv_o),
    .phy_i(conv_phy_i), .map_i(map),
    .valid_o(conv_valid_o), .log_o(conv_log_o)
  );

  AST_POL_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_known_o && !clear_i) |=> (pol_known_o && $stable(pol_inv_o))); // R2
  AST_BAD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !shape_ok && !clear_i) |=> $stable(valid)); // R4
  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clear_i) |=> done_o); // R6
endmodule

// File: tb/perm_learner_tb_top.sv
`timescale 1ns/1ps
module perm_learner_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        pv = 1'b0;
  logic        pready;
  logic [15:0] plog = '0, pphy = '0;
  logic        creq = 1'b0;
  logic [15:0] cphy = '0;
  logic        cvalid;
  logic [15:0] clog;
  logic        done, pknown, pinv, eshape, ecol;
  int          n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  perm_learner dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear),
    .probe_valid_i(pv), .probe_ready_o(pready),
    .probe_log_i(plog), .probe_phy_i(pphy),
    .conv_req_i(creq), .conv_phy_i(cphy),
    .conv_valid_o(cvalid), .conv_log_o(clog),
    .done_o(done), .pol_known_o(pknown), .pol_inv_o(pinv),
    .err_shape_o(eshape), .err_collide_o(ecol)
  );

  function automatic int pmap(int a, int b, int l);
    return (a * l + b) % 16;
  endfunction

  function automatic logic [15:0] exp_log(logic [15:0] v, int a, int b, logic inv);
    logic [15:0] r;
    for (int l = 0; l < 16; l++) r[l] = v[pmap(a, b, l)] ^ inv;
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic probe(logic [15:0] lv, logic [15:0] phv);
    @(negedge clk);
    pv = 1'b1; plog = lv; pphy = phv;
    @(negedge clk);
    pv = 1'b0;
  endtask

  task automatic learn(int a, int b, logic inv, int from);
    for (int l = from; l < 16; l++) begin
      logic [15:0] r;
      r = 16'(1) << pmap(a, b, l);
      probe(16'(1) << l, inv ? ~r : r);
    end
  endtask

  task automatic conv(logic [15:0] v);
    @(negedge clk);
    creq = 1'b1; cphy = v;
    @(negedge clk);
    creq = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic sweep(int a, int b, logic inv, string req, int cnt);
    logic [15:0] x;
    x = 16'hACE1;
    for (int i = 0; i < cnt; i++) begin
      x = x * 16'd25173 + 16'd13849;
      conv(x);
      chk(cvalid && clog == exp_log(x, a, b, inv), req, clog, exp_log(x, a, b, inv));
    end
  endtask

  task automatic chk_idle(string req);
    chk(!done && pready && !pknown && !pinv && !eshape && !ecol, req,
        {10'd0, done, pready, pknown, pinv, eshape, ecol}, 16'h0010);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after reset");

    // conversion before done is dropped
    conv(16'hFFFF);
    chk(!cvalid, "R8 conv before done", {15'd0, cvalid}, 16'h0);

    // plain polarity, permutation 5l+10 (7 -> 13)
    probe(16'h0001, 16'(1) << pmap(5, 10, 0));
    chk(pknown && !pinv, "R2 plain detect", {14'd0, pknown, pinv}, 16'h2);
    learn(5, 10, 1'b0, 1);
    chk(done && !pready && !eshape && !ecol, "R6 done plain",
        {12'd0, done, pready, eshape, ecol}, 16'h8);
    conv(16'h2000);
    chk(cvalid && clog == 16'h0080, "R3 entry 7->13", clog, 16'h0080);
    sweep(5, 10, 1'b0, "R7 plain sweep", 200);

    // probe while done is ignored
    probe(16'h0001, 16'(1) << pmap(5, 10, 7));
    conv(16'(1) << pmap(5, 10, 0));
    chk(clog == 16'h0001 && !eshape && !ecol, "R6 ignored after done", clog, 16'h0001);

    // clear, complemented polarity, permutation 3l+7
    do_clear();
    chk_idle("R1 clear");
    conv(16'h1234);
    chk(!cvalid, "R8 conv after clear", {15'd0, cvalid}, 16'h0);
    probe(16'h0001, ~(16'(1) << pmap(3, 7, 0)));
    chk(pknown && pinv, "R2 complement detect", {14'd0, pknown, pinv}, 16'h3);
    probe(16'h0002, 16'(1) << pmap(3, 7, 1));
    chk(eshape && pinv, "R2 polarity mismatch", {14'd0, eshape, pinv}, 16'h3);
    learn(3, 7, 1'b1, 1);
    chk(done && pinv, "R6 done complement", {14'd0, done, pinv}, 16'h3);
    sweep(3, 7, 1'b1, "R7 complement sweep", 200);

    // malformed probes
    do_clear();
    probe(16'h0001, 16'h0003);
    chk(eshape && !pknown, "R4 bad response", {14'd0, eshape, pknown}, 16'h2);
    do_clear();
    probe(16'h0003, 16'(1) << pmap(5, 10, 0));
    chk(eshape && !pknown, "R4 bad logical", {14'd0, eshape, pknown}, 16'h2);
    learn(5, 10, 1'b0, 1);
    chk(!done, "R4 entry left invalid", {15'd0, done}, 16'h0);
    learn(5, 10, 1'b0, 0);
    chk(done, "R4 refill", {15'd0, done}, 16'h1);
    sweep(5, 10, 1'b0, "R4 map after refill", 20);

    // collision
    do_clear();
    probe(16'h0004, 16'(1) << pmap(5, 10, 2));
    probe(16'h0004, 16'(1) << pmap(5, 10, 2));
    chk(!ecol && !eshape, "R5 repeat pair", {14'd0, ecol, eshape}, 16'h0);
    probe(16'h0001, 16'(1) << pmap(5, 10, 0));
    probe(16'h0002, 16'(1) << pmap(5, 10, 0));
    chk(ecol && !eshape, "R5 collision", {14'd0, ecol, eshape}, 16'h2);
    learn(5, 10, 1'b0, 1);
    chk(done && ecol, "R5 done after collision", {14'd0, done, ecol}, 16'h3);
    sweep(5, 10, 1'b0, "R5 map intact", 20);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule